// File: doc/BRIEF.md
# Supervisory Reset Pulse Extender

This block drives a shared, active-low reset line in open-drain fashion. It only ever pulls the line low and never drives it high. It is clocked, and it combines three inputs. The first is a digital undervoltage flag from an external comparator. The second is the block's own asynchronous power-on reset. The third is the sensed level of the reset line, so the line serves as both output and input.

After power-on, the block holds the line low until the supply has been reported good for a full hold period. Undervoltage pulses no longer than a glitch filter window are ignored. A longer undervoltage pulls the line low at once, keeps it low while the condition lasts, and then extends the reset by the hold period.

Another device can pull the line low. On the leading edge of that external low, the block starts its own hold pulse. The visible reset therefore lasts for the hold period or for the external low, whichever is longer. While its own drive is active, the block ignores falling edges on the line.

Top module: `sup_reset_ext`

## Requirements
- R1: While rst_n is low, pin_drive_low and reset_active are both 1.
- R2: After rst_n rises with uv_flag low, pin_drive_low stays 1 for exactly HOLD_CYCLES clock edges and is 0 from the HOLD_CYCLES-th edge on.
- R3: Release needs HOLD_CYCLES consecutive supply-good samples. A uv_flag pulse during a hold, even one cycle long, restarts the count, so release comes HOLD_CYCLES+2 edges after the edge at which uv_flag was last sampled high.
- R4: While released, a uv_flag pulse lasting GLITCH_CYCLES cycles or fewer leaves pin_drive_low and reset_active at 0.
- R5: A uv_flag pulse lasting L > GLITCH_CYCLES cycles, first sampled high at edge 1, sets pin_drive_low from edge GLITCH_CYCLES+3 through edge L+HOLD_CYCLES+1 inclusive.
- R6: While released, a falling edge on pin_sense, first sampled low at edge 1, sets pin_drive_low from edge 3 for exactly HOLD_CYCLES edges.
- R7: Falling edges on pin_sense that arrive while pin_drive_low is 1 do not restart or lengthen the hold.
- R8: If the line is held low externally for P edges, pin_drive_low still releases after HOLD_CYCLES and does not retrigger while the line stays low. reset_active is high from edge 2 through edge max(P, HOLD_CYCLES+3)+1.
- R9: reset_active is 1 when pin_drive_low is 1 or when pin_sense, seen through a two-flop synchronizer, is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| uv_flag | input | 1 | Undervoltage flag from an external comparator, 1 = supply low |
| pin_sense | input | 1 | Sensed level of the shared reset line |
| pin_drive_low | output | 1 | 1 = pull the reset line low (the line is never driven high) |
| reset_active | output | 1 | 1 while the system is held in reset |

## Verification
The undervoltage flag is swept over pulse lengths from one cycle to beyond the filter window. This separates rejected glitches from accepted faults, and it pins down both the entry latency and the release time after the fault ends. A one-cycle undervoltage blip placed inside the power-on hold shows whether the hold count restarts.

External lows on the line are swept from one cycle to well past the hold period. Short pulses create a second falling edge while the block is already driving the line, which shows that such edges are masked. Long pulses show that the reset lasts for the longer of the two and that the block does not retrigger on a line it is not driving.

// File: rtl/sup_reset_ext.sv
`timescale 1ns/1ps
module sup_reset_ext #(
  parameter int unsigned HOLD_CYCLES   = 64,
  parameter int unsigned GLITCH_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_flag,
  input  logic pin_sense,
  output logic pin_drive_low,
  output logic reset_active
);
  localparam int unsigned CMAX = (HOLD_CYCLES > GLITCH_CYCLES) ? HOLD_CYCLES : GLITCH_CYCLES;
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] HLAST = CW'(HOLD_CYCLES - 1);
  localparam logic [CW-1:0] GMAX  = CW'(GLITCH_CYCLES);

  logic          uv_s1, uv_s;
  logic          pin_s1, pin_s, pin_d;
  logic [CW-1:0] gcnt, hcnt;
  logic          drv;
  logic          uv_bad, ext_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_s1  <= 1'b0;
      uv_s   <= 1'b0;
      pin_s1 <= 1'b0;
      pin_s  <= 1'b0;
      pin_d  <= 1'b0;
    end else begin
      uv_s1  <= uv_flag;
      uv_s   <= uv_s1;
      pin_s1 <= pin_sense;
      pin_s  <= pin_s1;
      pin_d  <= pin_s;
    end
  end

  assign uv_bad   = uv_s && (gcnt == GMAX);
  assign ext_fall = pin_d && !pin_s && !drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           gcnt <= '0;
    else if (!uv_s)       gcnt <= '0;
    else if (gcnt != GMAX) gcnt <= gcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv  <= 1'b1;
      hcnt <= '0;
    end else if (uv_bad || ext_fall) begin
      drv  <= 1'b1;
      hcnt <= '0;
    end else if (drv) begin
      if (uv_s)                hcnt <= '0;
      else if (hcnt == HLAST)  drv  <= 1'b0;
      else                     hcnt <= hcnt + 1'b1;
    end
  end

  assign pin_drive_low = drv;
  assign reset_active  = drv || !pin_s;
endmodule

// File: rtl/sup_reset_ext_chk.sv
`timescale 1ns/1ps
module sup_reset_ext_chk #(
  parameter int unsigned HOLD_CYCLES   = 64,
  parameter int unsigned GLITCH_CYCLES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic uv_flag,
  input logic uv_s,
  input logic pin_s,
  input logic drv
);
  localparam int CAP = 1 << 20;
  int uv_run, ok_run, hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_run <= 0;
      ok_run <= 0;
      hi_run <= 0;
    end else begin
      uv_run <= uv_flag ? ((uv_run < CAP) ? uv_run + 1 : uv_run) : 0;
      ok_run <= !uv_s   ? ((ok_run < CAP) ? ok_run + 1 : ok_run) : 0;
      hi_run <= drv     ? ((hi_run < CAP) ? hi_run + 1 : hi_run) : 0;
    end
  end

  p_uv_forces_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_run >= int'(GLITCH_CYCLES) + 3) |-> drv);

  p_release_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv) |-> (ok_run >= int'(HOLD_CYCLES)));

  p_min_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv) |-> (hi_run >= int'(HOLD_CYCLES)));

  p_edge_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv && $fell(pin_s)) |=> drv);
endmodule

bind sup_reset_ext sup_reset_ext_chk #(
  .HOLD_CYCLES(HOLD_CYCLES),
  .GLITCH_CYCLES(GLITCH_CYCLES)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .uv_flag(uv_flag),
  .uv_s(uv_s),
  .pin_s(pin_s),
  .drv(pin_drive_low)
);

// File: tb/sup_reset_ext_bench.sv
`timescale 1ns/1ps
module sup_reset_ext_bench;
  localparam int H = 8;
  localparam int G = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic uv_flag = 1'b0;
  logic ext_low = 1'b0;
  logic pin_sense, pin_drive_low, reset_active;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign pin_sense = ~(pin_drive_low | ext_low);

  sup_reset_ext #(.HOLD_CYCLES(H), .GLITCH_CYCLES(G)) u_sup_reset_ext (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .pin_sense(pin_sense),
    .pin_drive_low(pin_drive_low), .reset_active(reset_active)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, int n, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s edge %0d actual %b expected %b", req, what, n, act, exp);
    end
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic uv_trial(int len);
    string tag;
    logic hit;
    tag = (len > G) ? "R5" : "R4";
    hit = (len > G);
    uv_flag = 1'b1;
    for (int n = 1; n <= len + H + 10; n++) begin
      step();
      if (n == len) uv_flag = 1'b0;
      chk(tag, "uv drive", n, pin_drive_low, hit && n >= G + 3 && n <= len + 1 + H);
      chk(tag, "uv active", n, reset_active, hit && n >= G + 3 && n <= len + 3 + H);
    end
    idle(8);
  endtask

  task automatic pin_trial(int p);
    string tag;
    int span;
    span = (p > H + 3) ? p : H + 3;
    tag = (p < 3) ? "R7" : ((p > H + 3) ? "R8" : "R6");
    ext_low = 1'b1;
    for (int n = 1; n <= span + 8; n++) begin
      step();
      if (n == p) ext_low = 1'b0;
      chk(tag, "pin drive", n, pin_drive_low, n >= 3 && n <= H + 2);
      chk(tag == "R6" ? "R9" : tag, "pin active", n, reset_active, n >= 2 && n <= span + 1);
    end
    idle(8);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    idle(3);
    chk("R1", "reset drive", 0, pin_drive_low, 1'b1);
    chk("R1", "reset active", 0, reset_active, 1'b1);

    rst_n = 1'b1;
    for (int n = 1; n <= H + 4; n++) begin
      step();
      chk("R2", "powerup drive", n, pin_drive_low, n <= H - 1);
      chk("R9", "powerup active", n, reset_active, n <= H + 1);
    end
    idle(10);

    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    for (int n = 1; n <= H + 10; n++) begin
      step();
      if (n == 2) uv_flag = 1'b1;
      if (n == 3) uv_flag = 1'b0;
      chk("R3", "blip drive", n, pin_drive_low, n <= H + 4);
      chk("R3", "blip active", n, reset_active, n <= H + 6);
    end
    idle(10);

    for (int len = 1; len <= G + 3; len++) uv_trial(len);
    uv_trial(3 * H);

    for (int p = 1; p <= 2 * H + 4; p++) pin_trial(p);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule